// File: doc/BRIEF.md
# Variable-Length Instruction Splitter

This block looks at a six-byte window of instruction memory that starts at the current program counter. It splits one instruction of a small 32-bit register-based instruction set out of that window. The upper nibble of the first byte selects the instruction class. That class fixes how long the instruction is and where its register byte and 32-bit constant sit. The block reports the following outputs:

- the class code and the function code;
- both register specifiers;
- the constant word;
- the address of the next sequential instruction;
- a status code.

The block is purely combinational. The surrounding fetch stage reads the window from memory and supplies it. That stage also raises a flag when the fetch address lies outside memory. The block's outputs feed the decode and PC-select logic directly. It holds no state, so it has no clock or reset.

Byte k of the window is carried on bits [8k+7:8k]. Byte 0 is the byte at the program counter.

Top module: `ifetch_split`

## Requirements
- R1: `icode_o` always equals bits [7:4] of byte 0, and `ifun_o` always equals bits [3:0] of byte 0. This holds even when the instruction is invalid or the address faults.
- R2: For a valid instruction, the length is set by the class code:
  - 1 byte for classes 0x0 (halt), 0x1 (no-op) and 0x9 (return);
  - 2 bytes for classes 0x2 (register/conditional move), 0x6 (ALU), 0xA (push) and 0xB (pop);
  - 5 bytes for classes 0x7 (jump) and 0x8 (call);
  - 6 bytes for classes 0x3 (immediate move), 0x4 (store) and 0x5 (load).
  
  `next_pc_o` is `pc_in` plus that length, modulo 2^32.
- R3: In the 2-byte and 6-byte classes, `ra_o` is bits [7:4] of byte 1 and `rb_o` is bits [3:0] of byte 1. They are reported as encoded, including the value 0xF.
- R4: In the 6-byte classes, `valc_o` is bytes 2..5 taken little-endian, so byte 2 is the least significant. In the 5-byte classes, `valc_o` is bytes 1..4 taken little-endian.
- R5: When the class has no register byte, `ra_o` and `rb_o` are both 0xF. When the class has no constant, `valc_o` is 0.
- R6: An instruction is invalid in any of these cases:
  - the class code is above 0xB;
  - the function code is above 6 for class 0x2 or class 0x7;
  - the function code is above 3 for class 0x6;
  - the function code is nonzero for any other class.
  
  An invalid instruction gives status 4, a length of 1, `ra_o` = `rb_o` = 0xF and `valc_o` = 0.
- R7: A valid class-0x0 instruction gives status 2. Every other valid instruction gives status 1.
- R8: When `addr_fault_in` is 1, the status is 3, which takes priority over 4 and 2. All other outputs keep their decoded values.
- R9: The window bytes 30 82 cd ab 00 00 decode to class 3, function 0, `ra_o` 8, `rb_o` 2, constant 0x0000abcd and a length of 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_in | input | 32 | Address of byte 0 of the window |
| win_in | input | 48 | Six instruction bytes; byte k is at [8k+7:8k] |
| addr_fault_in | input | 1 | Fetch address is outside memory |
| icode_o | output | 4 | Instruction class code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register specifier, or 0xF |
| rb_o | output | 4 | Second register specifier, or 0xF |
| valc_o | output | 32 | Constant word, or 0 |
| next_pc_o | output | 32 | Address of the next sequential instruction |
| stat_o | output | 3 | 1 normal, 2 halt, 3 bad address, 4 invalid |

## Verification
Directed windows try every class with legal function codes, which separates the four lengths and the two constant positions. The sample immediate-move encoding pins down the byte order of the constant. Windows with the largest legal function code and the next value above it tell an off-by-one legality limit apart from a correct one. A fault flag set together with an invalid byte or a halt byte shows whether the status priority is applied in the right order. Random windows with PC values near the top of the address space, checked against a reference model, exercise the field extraction and the address wrap.

// File: rtl/ifetch_split_pkg.sv
package ifetch_split_pkg;

    typedef enum logic [3:0] {
        OP_HALT  = 4'h0,
        OP_NOP   = 4'h1,
        OP_RRMOV = 4'h2,
        OP_IRMOV = 4'h3,
        OP_STORE = 4'h4,
        OP_LOAD  = 4'h5,
        OP_ALU   = 4'h6,
        OP_JUMP  = 4'h7,
        OP_CALL  = 4'h8,
        OP_RET   = 4'h9,
        OP_PUSH  = 4'hA,
        OP_POP   = 4'hB
    } op_e;

    // Instruction layout classes
    typedef enum logic [1:0] {
        FMT_BARE   = 2'd0,  // opcode byte only
        FMT_REGS   = 2'd1,  // opcode + register byte
        FMT_DEST   = 2'd2,  // opcode + constant
        FMT_REGVAL = 2'd3   // opcode + register byte + constant
    } fmt_e;

    typedef enum logic [2:0] {
        ST_OK  = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4
    } stat_e;

    localparam logic [3:0] NO_REG = 4'hF;

endpackage

// File: rtl/ifetch_split_format.sv
module ifetch_split_format
    import ifetch_split_pkg::*;
(
    input  logic [3:0] icode_i,
    output fmt_e       fmt_o,
    output logic [3:0] fun_lim_o,
    output logic       known_o
);
    always_comb begin
        fmt_o     = FMT_BARE;
        fun_lim_o = 4'd0;
        known_o   = 1'b1;
        unique case (icode_i)
            OP_HALT, OP_NOP, OP_RET:  fmt_o = FMT_BARE;
            OP_RRMOV: begin
                fmt_o     = FMT_REGS;
                fun_lim_o = 4'd6;
            end
            OP_ALU: begin
                fmt_o     = FMT_REGS;
                fun_lim_o = 4'd3;
            end
            OP_PUSH, OP_POP:          fmt_o = FMT_REGS;
            OP_JUMP: begin
                fmt_o     = FMT_DEST;
                fun_lim_o = 4'd6;
            end
            OP_CALL:                  fmt_o = FMT_DEST;
            OP_IRMOV, OP_STORE, OP_LOAD: fmt_o = FMT_REGVAL;
            default:                  known_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ifetch_split_fields.sv
module ifetch_split_fields
    import ifetch_split_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int WIN_BYTES = 2 + WORD_W / 8,
    parameter int LEN_W     = $clog2(WIN_BYTES + 1)
) (
    input  fmt_e                     fmt_i,
    input  logic [8*WIN_BYTES-1:0]   win_i,
    output logic [3:0]               ra_o,
    output logic [3:0]               rb_o,
    output logic [WORD_W-1:0]        valc_o,
    output logic [LEN_W-1:0]         len_o
);
    localparam int CBYTES = WORD_W / 8;

    logic [WORD_W-1:0] const_after_op;
    logic [WORD_W-1:0] const_after_reg;

    // Byte k of the window occupies [8k +: 8], so slicing gives little-endian order.
    assign const_after_op  = win_i[8 +: WORD_W];
    assign const_after_reg = win_i[16 +: WORD_W];

    always_comb begin
        ra_o   = NO_REG;
        rb_o   = NO_REG;
        valc_o = '0;
        len_o  = LEN_W'(1);
        unique case (fmt_i)
            FMT_BARE: len_o = LEN_W'(1);
            FMT_REGS: begin
                ra_o  = win_i[15:12];
                rb_o  = win_i[11:8];
                len_o = LEN_W'(2);
            end
            FMT_DEST: begin
                valc_o = const_after_op;
                len_o  = LEN_W'(1 + CBYTES);
            end
            FMT_REGVAL: begin
                ra_o   = win_i[15:12];
                rb_o   = win_i[11:8];
                valc_o = const_after_reg;
                len_o  = LEN_W'(2 + CBYTES);
            end
        endcase
    end
endmodule

// File: rtl/ifetch_split.sv
module ifetch_split
    import ifetch_split_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int WIN_BYTES = 2 + WORD_W / 8
) (
    input  logic [ADDR_W-1:0]        pc_in,
    input  logic [8*WIN_BYTES-1:0]   win_in,
    input  logic                     addr_fault_in,
    output logic [3:0]               icode_o,
    output logic [3:0]               ifun_o,
    output logic [3:0]               ra_o,
    output logic [3:0]               rb_o,
    output logic [WORD_W-1:0]        valc_o,
    output logic [ADDR_W-1:0]        next_pc_o,
    output logic [2:0]               stat_o
);
    localparam int LEN_W = $clog2(WIN_BYTES + 1);

    fmt_e              raw_fmt;
    fmt_e              eff_fmt;
    logic [3:0]        fun_lim;
    logic              known;
    logic              legal;
    logic [LEN_W-1:0]  ilen;

    assign icode_o = win_in[7:4];
    assign ifun_o  = win_in[3:0];

    ifetch_split_format u_format (
        .icode_i   (icode_o),
        .fmt_o     (raw_fmt),
        .fun_lim_o (fun_lim),
        .known_o   (known)
    );

    assign legal   = known && (ifun_o <= fun_lim);
    assign eff_fmt = legal ? raw_fmt : FMT_BARE;

    ifetch_split_fields #(
        .WORD_W    (WORD_W),
        .WIN_BYTES (WIN_BYTES),
        .LEN_W     (LEN_W)
    ) u_fields (
        .fmt_i  (eff_fmt),
        .win_i  (win_in),
        .ra_o   (ra_o),
        .rb_o   (rb_o),
        .valc_o (valc_o),
        .len_o  (ilen)
    );

    assign next_pc_o = pc_in + {{(ADDR_W-LEN_W){1'b0}}, ilen};

    // Priority: bad address, then invalid, then halt
    always_comb begin
        if (addr_fault_in)               stat_o = ST_ADR;
        else if (!legal)                 stat_o = ST_INS;
        else if (icode_o == OP_HALT)     stat_o = ST_HLT;
        else                             stat_o = ST_OK;
    end
endmodule

// File: rtl/ifetch_split_chk.sv
module ifetch_split_chk #(
    parameter int ADDR_W    = 32,
    parameter int WORD_W    = 32,
    parameter int WIN_BYTES = 2 + WORD_W / 8
) (
    input logic [ADDR_W-1:0]      pc_in,
    input logic [8*WIN_BYTES-1:0] win_in,
    input logic                   addr_fault_in,
    input logic [3:0]             icode_o,
    input logic [3:0]             ifun_o,
    input logic [3:0]             ra_o,
    input logic [3:0]             rb_o,
    input logic [WORD_W-1:0]      valc_o,
    input logic [ADDR_W-1:0]      next_pc_o,
    input logic [2:0]             stat_o
);
    logic [ADDR_W-1:0] step;
    assign step = next_pc_o - pc_in;

    always_comb begin
        if (!$isunknown({pc_in, win_in, addr_fault_in})) begin
            assert_nibbles_R1: assert (icode_o == win_in[7:4] && ifun_o == win_in[3:0]);
            assert_len_set_R2: assert (step == 1 || step == 2 || step == 5 || step == 6);
            assert_bare_regs_R5: assert (!(step == 1 || step == 5) || (ra_o == 4'hF && rb_o == 4'hF));
            assert_noconst_R5: assert (!(step == 1 || step == 2) || valc_o == '0);
            assert_inv_clean_R6: assert (stat_o != 3'd4 || (step == 1 && ra_o == 4'hF && valc_o == '0));
            assert_halt_code_R7: assert (stat_o != 3'd2 || icode_o == 4'h0);
            assert_fault_first_R8: assert (addr_fault_in == (stat_o == 3'd3));
        end
    end
endmodule

bind ifetch_split ifetch_split_chk #(
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .WIN_BYTES (WIN_BYTES)
) i_chk (
    .pc_in         (pc_in),
    .win_in        (win_in),
    .addr_fault_in (addr_fault_in),
    .icode_o       (icode_o),
    .ifun_o        (ifun_o),
    .ra_o          (ra_o),
    .rb_o          (rb_o),
    .valc_o        (valc_o),
    .next_pc_o     (next_pc_o),
    .stat_o        (stat_o)
);

// File: tb/test_ifetch_split.sv
module test_ifetch_split;
    logic        clk = 1'b0;
    logic [31:0] pc = '0;
    logic [47:0] win = '0;
    logic        fault = 1'b0;
    logic [3:0]  icode, ifun, ra, rb;
    logic [31:0] valc, npc;
    logic [2:0]  stat;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    ifetch_split i_ifetch_split (
        .pc_in(pc), .win_in(win), .addr_fault_in(fault),
        .icode_o(icode), .ifun_o(ifun), .ra_o(ra), .rb_o(rb),
        .valc_o(valc), .next_pc_o(npc), .stat_o(stat)
    );

    function automatic bit is_legal(input logic [3:0] c, input logic [3:0] f);
        if (c > 4'hB) return 0;
        if (c == 4'h2 || c == 4'h7) return f <= 4'd6;
        if (c == 4'h6) return f <= 4'd3;
        return f == 4'd0;
    endfunction

    task automatic model(input logic [31:0] p, input logic [47:0] w, input logic flt,
                         output logic [3:0] e_ra, output logic [3:0] e_rb,
                         output logic [31:0] e_c, output logic [31:0] e_np,
                         output logic [2:0] e_st);
        logic [3:0] c = w[7:4];
        logic [3:0] f = w[3:0];
        int len = 1;
        e_ra = 4'hF; e_rb = 4'hF; e_c = 0;
        if (is_legal(c, f)) begin
            case (c)
                4'h2, 4'h6, 4'hA, 4'hB: begin len = 2; e_ra = w[15:12]; e_rb = w[11:8]; end
                4'h7, 4'h8: begin len = 5; e_c = {w[39:32], w[31:24], w[23:16], w[15:8]}; end
                4'h3, 4'h4, 4'h5: begin
                    len = 6; e_ra = w[15:12]; e_rb = w[11:8];
                    e_c = {w[47:40], w[39:32], w[31:24], w[23:16]};
                end
                default: len = 1;
            endcase
        end
        e_np = p + 32'(len);
        if (flt) e_st = 3'd3;
        else if (!is_legal(c, f)) e_st = 3'd4;
        else if (c == 4'h0) e_st = 3'd2;
        else e_st = 3'd1;
    endtask

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (win=%h pc=%h flt=%b)", tag, act, exp, win, pc, fault);
        end
    endtask

    task automatic apply(input logic [31:0] p, input logic [47:0] w, input logic flt);
        logic [3:0] e_ra, e_rb;
        logic [31:0] e_c, e_np;
        logic [2:0] e_st;
        @(negedge clk);
        pc = p; win = w; fault = flt;
        #2;
        model(p, w, flt, e_ra, e_rb, e_c, e_np, e_st);
        cmp("R1 icode", 32'(icode), 32'(w[7:4]));
        cmp("R1 ifun", 32'(ifun), 32'(w[3:0]));
        cmp("R2 next_pc", npc, e_np);
        cmp("R3/R5 ra", 32'(ra), 32'(e_ra));
        cmp("R3/R5 rb", 32'(rb), 32'(e_rb));
        cmp("R4/R5 valc", valc, e_c);
        cmp("R6/R7/R8 stat", 32'(stat), 32'(e_st));
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1D5EED);
        // R9: sample immediate-move encoding
        apply(32'h100, 48'h0000_abcd_8230, 0);
        cmp("R9 ra", 32'(ra), 32'h8);
        cmp("R9 rb", 32'(rb), 32'h2);
        cmp("R9 valc", valc, 32'h0000abcd);
        cmp("R9 len", npc, 32'h106);
        // R7: halt; R2: one-byte forms
        apply(32'h0, 48'h0, 0);
        cmp("R7 halt status", 32'(stat), 32'd2);
        apply(32'h40, 48'hFFFF_FFFF_FF10, 0);
        apply(32'h44, 48'h1234_5678_9A90, 0);
        // R4: jump and call constant position
        apply(32'h200, 48'h99_1122_3344_76, 0);
        cmp("R4 jump dest", valc, 32'h11223344);
        apply(32'h300, 48'h77_DEAD_BEEF_80, 0);
        // R6: legality boundaries
        apply(32'h10, 48'h0000_0000_3426, 0);
        apply(32'h10, 48'h0000_0000_3427, 0);
        cmp("R6 cmov fun7 invalid", 32'(stat), 32'd4);
        apply(32'h10, 48'h0000_0000_0163, 0);
        apply(32'h10, 48'h0000_0000_0164, 0);
        cmp("R6 alu fun4 invalid", 32'(stat), 32'd4);
        apply(32'h10, 48'h0000_0000_01C0, 0);
        apply(32'h10, 48'h0000_0000_F031, 0);
        apply(32'h10, 48'h0000_0000_0001, 0);
        // R8: fault priority over invalid and halt
        apply(32'h20, 48'h0000_0000_00F5, 1);
        cmp("R8 fault over invalid", 32'(stat), 32'd3);
        apply(32'h20, 48'h0000_0000_0000, 1);
        apply(32'h20, 48'h0000_1234_5640, 1);
        // R2: PC wrap
        apply(32'hFFFF_FFFC, 48'h0000_0000_0F50, 0);
        cmp("R2 wrap", npc, 32'h2);
        // Random windows
        for (int i = 0; i < 600; i++) begin
            logic [47:0] w;
            logic [31:0] p;
            w = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
            if ($urandom_range(0, 3) != 0) w[7:4] = 4'($urandom_range(0, 11));
            if ($urandom_range(0, 2) != 0) w[3:0] = 4'($urandom_range(0, 3));
            p = ($urandom_range(0, 7) == 0) ? (32'hFFFF_FFF8 + 32'($urandom_range(0, 7))) : $urandom();
            apply(p, w, ($urandom_range(0, 9) == 0));
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=complete");
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule